// File: doc/BRIEF.md
# Static Memory Cycle Timing Generator

This block runs one access at a time to an external static memory and shapes its control strobes from programmed counts. A host raises a request with an address, byte enables, a direction and (for writes) data. The block then takes ownership of the memory pins for a fixed number of clocks and raises a one-clock acknowledge in the final clock. Reads drive chip select and the read strobe. Writes drive chip select, the write strobe and the data bus.

Each direction has its own set of counts. There is a strobe setup and a strobe pulse, and a separate chip-select setup and chip-select pulse. There is also a total cycle length. Setup and hold are counted from the start and end of the address-valid window. Hold is whatever the cycle length leaves after setup plus pulse. The programmed values are not checked: a zero pulse, or setup plus pulse longer than the cycle, gives undefined timing.

A mode bit per direction picks the edge that governs data. For reads it picks which signal's rising edge captures the read data. For writes it picks whether the data bus is driven for the whole cycle or only while chip select is asserted.

Top module: `smc_timing_gen`

## Requirements
- R1: After reset every setup count is 1, every pulse count is 1, both cycle lengths are 3 and both mode bits are 1. An access with these values drives its strobe and chip select low only in cycle 1 and acknowledges in cycle 2, leaving one hold clock.
- R2: Cycle 0 is the first clock period after the edge that accepts a request. In cycle k the strobe of the access direction (read strobe for reads, write strobe for writes) is low exactly when strobe_setup <= k < strobe_setup + strobe_pulse. The strobe of the other direction stays high.
- R3: In cycle k chip select is low exactly when cs_setup <= k < cs_setup + cs_pulse, using the chip-select counts of the access direction. It is high whenever no access is in progress.
- R4: An access lasts exactly C clocks, where C is the cycle length of its direction. `ack` is high for exactly one clock, cycle C-1. A request is accepted only on an edge where no access is in progress, and the clock after the last cycle is idle.
- R5: `mem_addr` equals the request address and `mem_be_n` equals the bitwise complement of the request byte enables from cycle 0 to cycle C-1. Both keep those values after the access until the next one is accepted, including when setup plus pulse equals C (zero hold).
- R6: A read captures `mem_din` into `rdata` on the edge that ends the controlling pulse. With read mode 1 this is the edge ending cycle strobe_setup+strobe_pulse-1. With read mode 0 it is the edge ending cycle cs_setup+cs_pulse-1. `rdata` holds that value afterwards.
- R7: During a write, `mem_dout` equals the request data. With write mode 1, `mem_doe` is high in all C cycles. With write mode 0, it is high only in cycles where chip select is low. `mem_doe` is never high during a read.
- R8: A clock with `cfg_wr` high writes `cfg_data` to the field chosen by `cfg_sel`. The codes are: 0 read strobe setup, 1 read strobe pulse, 2 read cs setup, 3 read cs pulse, 4 read cycle, 5 write strobe setup, 6 write strobe pulse, 7 write cs setup, 8 write cs pulse, 9 write cycle, and 10 modes (bit 0 read mode, bit 1 write mode). A configuration write on an edge where an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration field code |
| cfg_data | input | CW | Configuration value |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| ack | output | 1 | High in the last clock of an access |
| rdata | output | DW | Captured read data |
| mem_addr | output | AW | Memory address |
| mem_be_n | output | DW/8 | Byte selects, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_dout | output | DW | Write data toward memory |
| mem_doe | output | 1 | Write data output enable |
| mem_din | input | DW | Read data from memory |

## Verification
The bench changes `mem_din` in every clock of a read. The captured value therefore shows which edge was used: a design that samples one clock early or late, or that samples on the wrong signal for the read mode, returns a different pattern. Zero setup, zero hold (setup plus pulse equal to the cycle length) and chip-select windows that differ from the strobe window are all exercised. Each one catches an off-by-one in a window comparison, either as a strobe edge one clock out of place or as an address that changes when the cycle ends. A configuration write issued in the middle of an access checks that the running access keeps its length. It also checks that the next access uses the old value; a design that let the write through would acknowledge at the wrong clock.

// File: rtl/smc_timing_gen.sv
module smc_timing_gen #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 6,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [3:0]    cfg_sel,
  input  logic [CW-1:0] cfg_data,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [BW-1:0] req_be,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_be_n,
  output logic          mem_cs_n,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic [DW-1:0] mem_dout,
  output logic          mem_doe,
  input  logic [DW-1:0] mem_din
);

  localparam int NF = 10;
  localparam int WO = 5;

  logic [CW-1:0] tim [NF];
  logic          rmode, wmode;
  logic          busy, we_q;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] be_q;
  logic [DW-1:0] wdata_q, rdata_q;

  function automatic logic in_win(input logic [CW-1:0] k, input logic [CW-1:0] s,
                                  input logic [CW-1:0] p);
    return ({1'b0, k} >= {1'b0, s}) && ({1'b0, k} < ({1'b0, s} + {1'b0, p}));
  endfunction

  logic [CW-1:0] s_strb, p_strb, s_cs, p_cs, cyc;
  assign s_strb = we_q ? tim[WO+0] : tim[0];
  assign p_strb = we_q ? tim[WO+1] : tim[1];
  assign s_cs   = we_q ? tim[WO+2] : tim[2];
  assign p_cs   = we_q ? tim[WO+3] : tim[3];
  assign cyc    = we_q ? tim[WO+4] : tim[4];

  logic strb_on, cs_on, last, cap;
  logic [CW:0] rend;
  assign strb_on = busy && in_win(cnt, s_strb, p_strb);
  assign cs_on   = busy && in_win(cnt, s_cs, p_cs);
  assign last    = busy && (({1'b0, cnt} + 1'b1) >= {1'b0, cyc});
  assign rend    = rmode ? ({1'b0, s_strb} + {1'b0, p_strb} - 1'b1)
                         : ({1'b0, s_cs} + {1'b0, p_cs} - 1'b1);
  assign cap     = busy && !we_q && ({1'b0, cnt} == rend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++)
        tim[i] <= (i == 4 || i == WO + 4) ? CW'(3) : CW'(1);
      rmode <= 1'b1;
      wmode <= 1'b1;
    end else if (cfg_wr && !busy) begin
      if (cfg_sel < 4'(NF)) tim[cfg_sel] <= cfg_data;
      else if (cfg_sel == 4'(NF)) begin
        rmode <= cfg_data[0];
        wmode <= cfg_data[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      we_q    <= 1'b0;
      cnt     <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (!busy) begin
      if (req) begin
        busy    <= 1'b1;
        we_q    <= req_we;
        cnt     <= '0;
        addr_q  <= req_addr;
        be_q    <= req_be;
        wdata_q <= req_wdata;
      end
    end else if (last) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (cap) rdata_q <= mem_din;
  end

  assign ack      = last;
  assign rdata    = rdata_q;
  assign mem_addr = addr_q;
  assign mem_be_n = ~be_q;
  assign mem_cs_n = !cs_on;
  assign mem_rd_n = !(strb_on && !we_q);
  assign mem_wr_n = !(strb_on && we_q);
  assign mem_dout = wdata_q;
  assign mem_doe  = busy && we_q && (wmode || cs_on);

endmodule

// File: rtl/smc_timing_gen_chk.sv
module smc_timing_gen_chk #(
  parameter int AW = 16,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          ack,
  input logic [CW-1:0] cyc,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_rd_n,
  input logic          mem_wr_n,
  input logic          mem_doe
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_n || mem_wr_n); // R2
  AST_PINS_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n || !mem_rd_n || !mem_wr_n || mem_doe) |-> busy); // R3
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R4
  AST_ACK_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> busy); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack) |=> $stable(mem_addr)); // R5
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> !mem_doe); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack) |=> $stable(cyc)); // R8

endmodule

bind smc_timing_gen smc_timing_gen_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ack(ack), .cyc(cyc),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
  .mem_wr_n(mem_wr_n), .mem_doe(mem_doe)
);

// File: tb/test_smc_timing_gen.sv
module test_smc_timing_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [5:0]  cfg_data = '0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        ack, mem_cs_n, mem_rd_n, mem_wr_n, mem_doe;
  logic [15:0] rdata, mem_addr, mem_dout;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_din = '0;

  int n_chk = 0, n_fail = 0;
  int sh [10];
  bit shr = 1'b1, shw = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  smc_timing_gen i_smc_timing_gen (
    .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_data, .req, .req_we, .req_addr,
    .req_wdata, .req_be, .ack, .rdata, .mem_addr, .mem_be_n, .mem_cs_n,
    .mem_rd_n, .mem_wr_n, .mem_dout, .mem_doe, .mem_din
  );

  function automatic bit win(int k, int s, int p);
    return k >= s && k < s + p;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfgw(int sel, int val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 4'(sel); cfg_data = 6'(val);
    @(negedge clk);
    cfg_wr = 1'b0;
    if (sel < 10) sh[sel] = val;
    else begin shr = val[0]; shw = val[1]; end
  endtask

  task automatic access(bit we, logic [15:0] a, logic [15:0] d, logic [1:0] be,
                        bit poke);
    int o = we ? 5 : 0;
    int s = sh[o], p = sh[o+1], cs = sh[o+2], cp = sh[o+3], c = sh[o+4];
    int e = shr ? s + p - 1 : cs + cp - 1;
    logic [15:0] base = 16'hA5C3 ^ a;
    logic [1:0] ben = ~be;
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < c; k++) begin
      mem_din = base ^ 16'(k);
      if (poke && k == 0) begin
        cfg_wr = 1'b1; cfg_sel = we ? 4'd9 : 4'd4; cfg_data = 6'(c + 5);
      end
      chk("R3 cs_n", 32'(mem_cs_n), 32'(!win(k, cs, cp)));
      chk("R2 rd_n", 32'(mem_rd_n), 32'(we ? 1'b1 : !win(k, s, p)));
      chk("R2 wr_n", 32'(mem_wr_n), 32'(we ? !win(k, s, p) : 1'b1));
      chk("R4 ack", 32'(ack), 32'(k == c - 1));
      chk("R7 doe", 32'(mem_doe), 32'(we && (shw || win(k, cs, cp))));
      chk("R5 addr", 32'(mem_addr), 32'(a));
      chk("R5 be_n", 32'(mem_be_n), 32'(ben));
      if (we) chk("R7 dout", 32'(mem_dout), 32'(d));
      @(negedge clk);
      cfg_wr = 1'b0;
    end
    chk("R4 idle cs_n", 32'(mem_cs_n), 32'd1);
    chk("R4 idle ack", 32'(ack), 32'd0);
    chk("R5 addr held", 32'(mem_addr), 32'(a));
    if (!we) chk("R6 rdata", 32'(rdata), 32'(base ^ 16'(e)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 10; i++) sh[i] = (i == 4 || i == 9) ? 3 : 1;
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", 32'(mem_cs_n), 32'd1);
    chk("R1 reset strobes", 32'({mem_rd_n, mem_wr_n}), 32'd3);
    chk("R1 reset ack/doe", 32'({ack, mem_doe}), 32'd0);
    rst_n = 1'b1;
    // R1: defaults, read then write
    access(1'b0, 16'h1234, 16'h0, 2'b11, 1'b0);
    access(1'b1, 16'h2468, 16'hBEEF, 2'b01, 1'b0);
    // R5: zero hold, zero setup write
    cfgw(5, 0); cfgw(6, 4); cfgw(7, 0); cfgw(8, 4); cfgw(9, 4);
    access(1'b1, 16'h0F0F, 16'h1357, 2'b10, 1'b0);
    // R6: read captured on chip-select edge (mode 0), windows differ
    cfgw(0, 2); cfgw(1, 2); cfgw(2, 1); cfgw(3, 4); cfgw(4, 6);
    cfgw(10, 2);
    access(1'b0, 16'h4444, 16'h0, 2'b11, 1'b0);
    cfgw(10, 3);
    access(1'b0, 16'h5555, 16'h0, 2'b11, 1'b0);
    // R7: write data only while chip select low
    cfgw(5, 1); cfgw(6, 2); cfgw(7, 2); cfgw(8, 2); cfgw(9, 6); cfgw(10, 1);
    access(1'b1, 16'h6666, 16'hCAFE, 2'b11, 1'b0);
    // R8: config writes during access ignored
    access(1'b0, 16'h7777, 16'h0, 2'b11, 1'b1);
    access(1'b0, 16'h7778, 16'h0, 2'b11, 1'b0);
    access(1'b1, 16'h7779, 16'hD00D, 2'b10, 1'b1);
    access(1'b1, 16'h777A, 16'hD00E, 2'b01, 1'b0);
    // random mix over R2..R7
    for (int n = 0; n < 60; n++) begin
      bit we = 1'($urandom);
      int o = we ? 5 : 0;
      int s = int'($urandom % 4), p = 1 + int'($urandom % 4);
      int cs = int'($urandom % 4), cp = 1 + int'($urandom % 4);
      int c = ((s + p > cs + cp) ? s + p : cs + cp) + int'($urandom % 3);
      cfgw(o, s); cfgw(o + 1, p); cfgw(o + 2, cs); cfgw(o + 3, cp); cfgw(o + 4, c);
      cfgw(10, int'($urandom % 4));
      access(we, 16'($urandom), 16'($urandom), 2'($urandom), 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule